// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a received line bit stream and drives an active-low alarm when the signal is essentially all ones. It does not look for any framing word. It counts zeros over a fixed window that holds roughly a third of a millisecond of bits. A window whose zero count stays at or below a rate-dependent threshold is called quiet. Two quiet windows in a row declare the alarm. The threshold sits near three times the zero count expected from a 1e-3 bit error rate, so a noisy all-ones signal is still detected. A framed signal whose payload is all ones still carries the zeros of its alignment word, and those push every window over the threshold.

The line clock drives the block. A bit strobe marks the cycles that carry a received bit. A rate input picks the slow (8448 kbit/s) or fast (34368 kbit/s) window length and threshold. While the neighbouring framer reports frame alignment, a quiet window does not count toward a declaration. Any window with too many zeros clears the alarm.

Top module: `ais_detector`

## Requirements
- R1: While reset is applied and after it is released, `ais_n` is high until a declaration occurs.
- R2: A window spans exactly 2816 strobed bits when `rate_hi` is 0 and 11456 strobed bits when `rate_hi` is 1; windows run back to back from reset.
- R3: A window whose zero count is at or below the threshold is quiet; when two consecutive quiet windows end with `frame_ok` low, `ais_n` goes low on the clock edge that takes the last bit of the second window.
- R4: A window with more zeros than the threshold drives `ais_n` high at its last bit and restarts the quiet-window run.
- R5: A quiet window that ends while `frame_ok` is high restarts the quiet-window run and leaves `ais_n` unchanged.
- R6: The threshold is 9 zeros at the slow rate and 34 zeros at the fast rate; exactly the threshold is quiet, one more is not.
- R7: Cycles with `bit_en` low are ignored: their `bit_in` value is not counted and they do not advance the window.
- R8: After an all-ones signal with a 1e-3 error rate begins at any point in a window, `ais_n` falls within 8448 bits (1 ms) at the slow rate.
- R9: `ais_n` changes only on the clock edge that takes the last bit of a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | High on cycles that carry a received bit |
| bit_in | input | 1 | Received data bit |
| rate_hi | input | 1 | 0 selects the slow rate, 1 the fast rate |
| frame_ok | input | 1 | High while the framer reports frame alignment |
| ais_n | output | 1 | Active-low all-ones alarm |

## Verification
The bench probes the threshold from both sides at both rates. Exactly 9 or 34 zeros must count as quiet, and one more must not. A design with an off-by-one compare would declare the alarm one window early or late, or would fail to clear it. The bench checks the alarm one bit before a window closes and again just after, which catches a window length that is off by one. It also checks that a run of quiet windows seen while the framer reports alignment does not carry over into a later declaration. Another test fills the gaps where `bit_en` is low with zeros; a detector that counted those cycles would never declare.

// File: rtl/ais_pkg.sv
package ais_pkg;
  // Result handed from the zero counter to the decision stage.
  typedef struct packed {
    logic done;   // last bit of a window taken this cycle
    logic quiet;  // zero count of that window at or below threshold
  } win_verdict_t;
endpackage

// File: rtl/ais_rst_sync.sv
module ais_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/ais_win_timer.sv
module ais_win_timer #(
  parameter int LEN_LO = 2816,
  parameter int LEN_HI = 11456
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic bit_en,
  input  logic rate_hi,
  output logic win_end
);
  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int CW      = $clog2(LEN_MAX);
  localparam logic [CW-1:0] LAST_LO = CW'(LEN_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(LEN_HI - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_idx;
  logic          at_end;

  always_comb begin
    last_idx = rate_hi ? LAST_HI : LAST_LO;
    at_end   = bit_en && (cnt_q >= last_idx);
    cnt_d    = cnt_q;
    if (at_end)      cnt_d = '0;
    else if (bit_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign win_end = at_end;
endmodule

// File: rtl/ais_zero_count.sv
module ais_zero_count
  import ais_pkg::*;
#(
  parameter int THR_LO = 9,
  parameter int THR_HI = 34
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         bit_en,
  input  logic         bit_in,
  input  logic         rate_hi,
  input  logic         win_end,
  output win_verdict_t verdict
);
  localparam int THR_MAX = (THR_HI > THR_LO) ? THR_HI : THR_LO;
  localparam int SAT     = THR_MAX + 1;
  localparam int ZW      = $clog2(SAT + 1);

  logic [ZW-1:0] zq, zd, znow, thr;

  always_comb begin
    thr  = rate_hi ? ZW'(THR_HI) : ZW'(THR_LO);
    znow = zq;
    if (bit_en && !bit_in && (zq != ZW'(SAT))) znow = zq + 1'b1;
    zd = win_end ? '0 : znow;
    verdict.done  = win_end;
    verdict.quiet = (znow <= thr);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) zq <= '0;
    else         zq <= zd;
  end
endmodule

// File: rtl/ais_decide.sv
module ais_decide
  import ais_pkg::*;
#(
  parameter int RUN_NEED = 2
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  win_verdict_t verdict,
  input  logic         frame_ok,
  output logic         alarm
);
  localparam int RW = $clog2(RUN_NEED + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_NEED);

  logic [RW-1:0] run_q, run_d;
  logic          alarm_q, alarm_d;

  always_comb begin
    run_d   = run_q;
    alarm_d = alarm_q;
    if (verdict.done) begin
      if (!verdict.quiet) begin
        run_d   = '0;
        alarm_d = 1'b0;
      end else if (frame_ok) begin
        run_d = '0;
      end else begin
        if (run_q != RUN_TOP) run_d = run_q + 1'b1;
        if (run_q + 1'b1 >= RUN_TOP) alarm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      run_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/ais_detector.sv
module ais_detector
  import ais_pkg::*;
#(
  parameter int LEN_LO   = 2816,
  parameter int LEN_HI   = 11456,
  parameter int THR_LO   = 9,
  parameter int THR_HI   = 34,
  parameter int RUN_NEED = 2,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic rate_hi,
  input  logic frame_ok,
  output logic ais_n
);
  logic         rst_ns;
  logic         win_end;
  logic         alarm;
  win_verdict_t verdict;

  ais_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  ais_win_timer #(.LEN_LO(LEN_LO), .LEN_HI(LEN_HI)) u_timer (
    .clk(clk), .rst_ns(rst_ns), .bit_en(bit_en), .rate_hi(rate_hi),
    .win_end(win_end)
  );

  ais_zero_count #(.THR_LO(THR_LO), .THR_HI(THR_HI)) u_zeros (
    .clk(clk), .rst_ns(rst_ns), .bit_en(bit_en), .bit_in(bit_in),
    .rate_hi(rate_hi), .win_end(win_end), .verdict(verdict)
  );

  ais_decide #(.RUN_NEED(RUN_NEED)) u_decide (
    .clk(clk), .rst_ns(rst_ns), .verdict(verdict), .frame_ok(frame_ok),
    .alarm(alarm)
  );

  assign ais_n = ~alarm;
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
  parameter int LEN_LO = 2816,
  parameter int LEN_HI = 11456
) (
  input logic clk,
  input logic rst_ns,
  input logic bit_en,
  input logic rate_hi,
  input logic frame_ok,
  input logic win_end,
  input logic ais_n
);
  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int CW      = $clog2(LEN_MAX + 1);

  logic [CW-1:0] seen;
  int            cur_len;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     seen <= '0;
    else if (win_end) seen <= '0;
    else if (bit_en)  seen <= seen + 1'b1;
  end

  assign cur_len = rate_hi ? LEN_HI : LEN_LO;

  AST_WIN_END_ON_BIT: assert property (@(posedge clk) disable iff (!rst_ns)
    win_end |-> bit_en);                                          // R7
  AST_WIN_LEN_REACHED: assert property (@(posedge clk) disable iff (!rst_ns)
    win_end |-> (int'(seen) + 1 >= cur_len));                     // R2
  AST_WIN_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_ns)
    (bit_en && !win_end) |-> (int'(seen) + 1 < cur_len));         // R2
  AST_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(ais_n) |-> $past(win_end));                             // R9
  AST_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(ais_n) |-> $past(win_end));                             // R4
  AST_FALL_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(ais_n) |-> !$past(frame_ok));                           // R5
endmodule

bind ais_detector ais_detector_chk #(.LEN_LO(LEN_LO), .LEN_HI(LEN_HI)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .bit_en(bit_en), .rate_hi(rate_hi),
  .frame_ok(frame_ok), .win_end(win_end), .ais_n(ais_n)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
  localparam int LLO = 2816, LHI = 11456, TLO = 9, THI = 34;

  logic clk, rst_n, bit_en, bit_in, rate_hi, frame_ok, ais_n;
  int checks = 0, fails = 0;

  ais_detector u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .rate_hi(rate_hi), .frame_ok(frame_ok), .ais_n(ais_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  int m_cnt, m_zero, m_run;
  bit m_alarm;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_zero = 0; m_run = 0; m_alarm = 0;
    end else if (bit_en) begin
      int len, thr, z;
      len = rate_hi ? LHI : LLO;
      thr = rate_hi ? THI : TLO;
      z   = m_zero + (bit_in ? 0 : 1);
      if (m_cnt + 1 >= len) begin
        if (z > thr) begin m_run = 0; m_alarm = 0; end
        else if (frame_ok) m_run = 0;
        else begin m_run++; if (m_run >= 2) m_alarm = 1; end
        m_cnt = 0; m_zero = 0;
      end else begin
        m_cnt++; m_zero = z;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (ais_n !== ~m_alarm) begin
        fails++;
        $display("FAIL R9 model compare t=%0t actual=%b expected=%b", $time, ais_n, ~m_alarm);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic put(input logic b, input logic en, input logic fr);
    @(negedge clk);
    bit_in = b; bit_en = en; frame_ok = fr;
  endtask

  // n strobed bits, the first nz of them zero, then one idle cycle
  task automatic send(input int n, input int nz, input logic fr);
    for (int i = 0; i < n; i++) put(i < nz ? 1'b0 : 1'b1, 1'b1, fr);
    put(1'b1, 1'b0, fr);
  endtask

  task automatic do_reset(input logic rh);
    @(negedge clk);
    rst_n = 0; bit_en = 0; bit_in = 1; frame_ok = 0; rate_hi = rh;
    repeat (3) @(negedge clk);
    chk("R1 alarm high in reset", ais_n, 1'b1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 alarm high after reset", ais_n, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    do_reset(1'b0);
    // R3 / R6: first quiet window alone does not declare
    send(LLO, 0, 0);
    chk("R3 one quiet window", ais_n, 1'b1);
    send(LLO - 1, TLO, 0);
    chk("R9 high one bit before end", ais_n, 1'b1);
    send(1, 0, 0);
    chk("R6 exactly threshold is quiet, R3 declare", ais_n, 1'b0);
    // R4 / R6: threshold+1 clears
    send(LLO, TLO + 1, 0);
    chk("R4 noisy window clears", ais_n, 1'b1);
    // R5: framed quiet windows do not count
    send(LLO, 0, 1);
    send(LLO, 0, 1);
    chk("R5 framed quiet windows", ais_n, 1'b1);
    send(LLO, 0, 0);
    chk("R5 run restarted by framing", ais_n, 1'b1);
    send(LLO, 0, 0);
    chk("R3 declare after restart", ais_n, 1'b0);
    send(LLO, 0, 1);
    chk("R5 framed window holds alarm", ais_n, 1'b0);
    send(LLO, TLO + 1, 0);
    chk("R4 clear again", ais_n, 1'b1);
    // R7: gaps carry zeros that must be ignored
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < LLO; i++) begin
        put(1'b0, 1'b0, 0);
        put(1'b1, 1'b1, 0);
      end
    end
    put(1'b1, 1'b0, 0);
    chk("R7 gap zeros ignored, R2 strobed length", ais_n, 1'b0);
    send(LLO, TLO + 1, 0);
    chk("R4 clear after gaps", ais_n, 1'b1);
    // R8: onset mid-window with 1e-3 errors
    do_reset(1'b0);
    for (int i = 0; i < 1000; i++) put((i % 20) == 0 ? 1'b0 : 1'b1, 1'b1, 0);
    k = 0;
    while (ais_n === 1'b1 && k < 4 * LLO) begin
      put((k % 1000) == 999 ? 1'b0 : 1'b1, 1'b1, 0);
      k++;
    end
    put(1'b1, 1'b0, 0);
    chk("R8 declared within 1 ms", (k <= 3 * LLO) && (ais_n === 1'b0), 1'b1);
    // R2 / R6 fast rate
    do_reset(1'b1);
    send(LHI, THI, 0);
    chk("R2 fast first window", ais_n, 1'b1);
    send(LHI - 1, THI, 0);
    chk("R2 fast one bit before end", ais_n, 1'b1);
    send(1, 0, 0);
    chk("R6 fast threshold quiet", ais_n, 1'b0);
    send(LHI, THI + 1, 0);
    chk("R6 fast threshold+1 clears", ais_n, 1'b1);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule